// File: doc/BRIEF.md
# Host bus acquisition controller

This block lets a host controller borrow the address and data bus of an attached 8-bit CPU and hand it back. It also owns that CPU's reset line. The host issues one of four commands on a small valid/ready port: reset the CPU, request the bus, release the bus, or let the CPU run.

The block drives the active-low bus-request output and watches the active-low bus-acknowledge input. It drives a single enable for the host's address and memory-strobe drivers, and it keeps a four-state record of the CPU's condition. The acquired flag tells the host when it may run memory cycles. The memory cycles themselves live elsewhere.

The CPU may use either reset polarity. Right after the block's own reset, the reset pin is left undriven for one cycle and its pulled level is sampled. That level is then treated as the asserted reset level.

All waits are counted in system clock cycles:
- the acknowledge timeout, a number of ticks of a slow prescaled tick;
- the short reset pulse;
- the long start-up delay before reset is let go.

Each of them is a parameter.

Top module: `busown_ctrl`

## Requirements
- R1: While rst_n is low, cpu_rst_oe is 0, busreq_n is 1, bus_oe is 0 and cmd_ready is 0. In the first clock after rst_n rises, cpu_rst_sense is sampled as the asserted reset level. From then on, cpu_rst_oe is 1 and cpu_rst_drive is asserted (equal to that level), the state is RESET and cmd_ready is 1.
- R2: cpu_state encodes RESET=0, RESET_ACQ=1, RUNNING=2, RUNNING_ACQ=3. bus_acquired is 1 exactly when cpu_state is 1 or 3.
- R3: A Request (cmd_op=1) in RESET drives busreq_n low and deasserts reset in the cycle after acceptance. Once busack_n is low, it sets bus_oe and enters RESET_ACQ.
- R4: If a Request made in RESET sees no acknowledge, then after TIMEOUT_TICKS*TICK_CYC+1 cycles busreq_n returns high and reset is re-asserted, and the state stays RESET.
- R5: A Request in RUNNING drives busreq_n low. On acknowledge it sets bus_oe and enters RUNNING_ACQ. On timeout it returns busreq_n high and stays in RUNNING with reset deasserted.
- R6: A Release (cmd_op=2) in RESET_ACQ clears bus_oe and asserts reset at once. It keeps busreq_n low for PULSE_CYC cycles, then raises it. It waits for busack_n high or timeout and enters RESET.
- R7: A Release in RUNNING_ACQ clears bus_oe and raises busreq_n together. It waits for busack_n high or timeout and enters RUNNING with reset still deasserted.
- R8: A Run (cmd_op=3) in RESET keeps reset asserted for RUN_DLY_CYC cycles after acceptance, then deasserts it and enters RUNNING.
- R9: A Run in RESET_ACQ clears bus_oe and asserts reset for PULSE_CYC cycles, with busreq_n held low. It then deasserts reset, sets bus_oe again and enters RUNNING_ACQ.
- R10: A Reset (cmd_op=0) in any state clears bus_oe, asserts reset, raises busreq_n after PULSE_CYC cycles, waits for busack_n high or timeout and enters RESET.
- R11: A command with no transition from the current state has no effect on cpu_state, busreq_n, bus_oe or reset, and cmd_ready stays 1. These are Request in an acquired state, Release in RESET or RUNNING, and Run in RUNNING or RUNNING_ACQ.
- R12: cmd_ready is 0 while a command sequence is in progress, and a command presented then is not taken.
- R13: bus_oe is never 1 while busreq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | Command code: 0 reset, 1 request, 2 release, 3 run |
| cmd_ready | output | 1 | High when a command can be taken |
| busack_n | input | 1 | Bus acknowledge from the CPU, active low, synchronous to clk |
| cpu_rst_sense | input | 1 | Level read back from the CPU reset pin |
| cpu_rst_drive | output | 1 | Value driven onto the CPU reset pin |
| cpu_rst_oe | output | 1 | Output enable of the reset pin driver |
| busreq_n | output | 1 | Bus request to the CPU, active low |
| bus_oe | output | 1 | Enable of the host address and strobe drivers |
| bus_acquired | output | 1 | Host currently owns the bus |
| cpu_state | output | 2 | Current CPU condition record |

## Verification
The hardest case to reach from the ports is an acknowledge that never arrives. The bench's CPU model normally mirrors busreq_n onto busack_n one cycle later. For the timeout vectors it is switched off, and the bench counts the exact number of cycles busreq_n stays low before the block gives up.

The reset-polarity learning is reached only through a second block reset, taken with the sensed pin level flipped. The busy window is exercised by presenting a Reset while a Run delay is still counting, and then confirming that the final state is the Run's.

// File: rtl/busown_pkg.sv
package busown_pkg;

  typedef enum logic [1:0] {
    CPU_RESET     = 2'd0,
    CPU_RESET_ACQ = 2'd1,
    CPU_RUN       = 2'd2,
    CPU_RUN_ACQ   = 2'd3
  } cpu_state_e;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_REQUEST = 2'd1,
    OP_RELEASE = 2'd2,
    OP_RUN     = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_INIT,
    PH_IDLE,
    PH_ACK_LO,
    PH_HOLD_RST,
    PH_ACK_HI,
    PH_RUN_DLY,
    PH_PULSE
  } phase_e;

  // True when the host owns the bus in this state.
  function automatic logic holds_bus(cpu_state_e s);
    return (s == CPU_RESET_ACQ) || (s == CPU_RUN_ACQ);
  endfunction

  // True when the command has a defined transition from this state.
  function automatic logic op_has_effect(cpu_state_e s, op_e o);
    case (o)
      OP_RESET:   return 1'b1;
      OP_REQUEST: return !holds_bus(s);
      OP_RELEASE: return holds_bus(s);
      default:    return (s == CPU_RESET) || (s == CPU_RESET_ACQ);
    endcase
  endfunction

  // State reached when the bus has been granted.
  function automatic cpu_state_e with_bus(cpu_state_e s);
    return (s == CPU_RUN) ? CPU_RUN_ACQ : CPU_RESET_ACQ;
  endfunction

endpackage

// File: rtl/busown_delay.sv
module busown_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= len - 1'b1;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/busown_tick_timer.sv
module busown_tick_timer #(
  parameter int TICK_CYC      = 25_000_000,
  parameter int TIMEOUT_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int PRE_W  = $clog2(TICK_CYC + 1);
  localparam int LEFT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_CYC - 1);
  localparam logic [LEFT_W-1:0] LEFT_INI = LEFT_W'(TIMEOUT_TICKS);

  logic [PRE_W-1:0]  pre;
  logic [LEFT_W-1:0] left;
  logic              run;
  logic              tick;

  assign tick = run && (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      left <= '0;
      run  <= 1'b0;
    end else if (start) begin
      pre  <= '0;
      left <= LEFT_INI;
      run  <= 1'b1;
    end else if (run) begin
      if (tick) begin
        pre <= '0;
        if (left != '0) left <= left - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = run && (left == '0);
endmodule

// File: rtl/busown_seq.sv
module busown_seq
  import busown_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  input  logic       busack_n,
  input  logic       cpu_rst_sense,
  input  logic       dly_done,
  input  logic       tmo_expired,
  output logic       dly_start,
  output logic       dly_long,
  output logic       tmo_start,
  output logic       rst_level,
  output logic       rst_assert,
  output logic       rst_oe,
  output logic       busreq_n,
  output logic       bus_oe,
  output cpu_state_e state
);
  phase_e     ph;
  cpu_state_e final_st;
  op_e        op;
  logic       cmd_take;
  logic       op_live;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (ph == PH_IDLE);
  assign cmd_take  = cmd_valid && cmd_ready;
  assign op_live   = cmd_take && op_has_effect(state, op);

  assign dly_long  = (op == OP_RUN) && (state == CPU_RESET);
  assign dly_start = op_live && ((op == OP_RESET) || (op == OP_RUN) ||
                     ((op == OP_RELEASE) && (state == CPU_RESET_ACQ)));
  assign tmo_start = (op_live && ((op == OP_REQUEST) ||
                     ((op == OP_RELEASE) && (state == CPU_RUN_ACQ)))) ||
                     ((ph == PH_HOLD_RST) && dly_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_INIT;
      state      <= CPU_RESET;
      final_st   <= CPU_RESET;
      rst_level  <= 1'b0;
      rst_assert <= 1'b1;
      rst_oe     <= 1'b0;
      busreq_n   <= 1'b1;
      bus_oe     <= 1'b0;
    end else begin
      case (ph)
        PH_INIT: begin
          rst_level <= cpu_rst_sense;
          rst_oe    <= 1'b1;
          ph        <= PH_IDLE;
        end
        PH_IDLE: begin
          if (op_live) begin
            case (op)
              OP_RESET: begin
                bus_oe     <= 1'b0;
                rst_assert <= 1'b1;
                ph         <= PH_HOLD_RST;
              end
              OP_REQUEST: begin
                busreq_n <= 1'b0;
                if (state == CPU_RESET) rst_assert <= 1'b0;
                ph <= PH_ACK_LO;
              end
              OP_RELEASE: begin
                bus_oe <= 1'b0;
                if (state == CPU_RESET_ACQ) begin
                  rst_assert <= 1'b1;
                  ph         <= PH_HOLD_RST;
                end else begin
                  busreq_n <= 1'b1;
                  final_st <= CPU_RUN;
                  ph       <= PH_ACK_HI;
                end
              end
              default: begin
                if (state == CPU_RESET) begin
                  ph <= PH_RUN_DLY;
                end else begin
                  bus_oe     <= 1'b0;
                  rst_assert <= 1'b1;
                  ph         <= PH_PULSE;
                end
              end
            endcase
          end
        end
        PH_HOLD_RST: begin
          if (dly_done) begin
            busreq_n <= 1'b1;
            final_st <= CPU_RESET;
            ph       <= PH_ACK_HI;
          end
        end
        PH_ACK_HI: begin
          if (busack_n || tmo_expired) begin
            state <= final_st;
            ph    <= PH_IDLE;
          end
        end
        PH_ACK_LO: begin
          if (!busack_n) begin
            bus_oe <= 1'b1;
            state  <= with_bus(state);
            ph     <= PH_IDLE;
          end else if (tmo_expired) begin
            busreq_n <= 1'b1;
            if (state == CPU_RESET) rst_assert <= 1'b1;
            ph <= PH_IDLE;
          end
        end
        PH_RUN_DLY: begin
          if (dly_done) begin
            rst_assert <= 1'b0;
            state      <= CPU_RUN;
            ph         <= PH_IDLE;
          end
        end
        default: begin
          if (dly_done) begin
            rst_assert <= 1'b0;
            bus_oe     <= 1'b1;
            state      <= CPU_RUN_ACQ;
            ph         <= PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
  import busown_pkg::*;
#(
  parameter int TICK_CYC      = 25_000_000,
  parameter int TIMEOUT_TICKS = 20,
  parameter int PULSE_CYC     = 2_500,
  parameter int RUN_DLY_CYC   = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  input  logic       busack_n,
  input  logic       cpu_rst_sense,
  output logic       cpu_rst_drive,
  output logic       cpu_rst_oe,
  output logic       busreq_n,
  output logic       bus_oe,
  output logic       bus_acquired,
  output logic [1:0] cpu_state
);
  localparam int MAX_DLY = (PULSE_CYC > RUN_DLY_CYC) ? PULSE_CYC : RUN_DLY_CYC;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam logic [DLY_W-1:0] PULSE_LEN = DLY_W'(PULSE_CYC);
  localparam logic [DLY_W-1:0] RUN_LEN   = DLY_W'(RUN_DLY_CYC);

  logic             dly_start, dly_long, dly_done;
  logic             tmo_start, tmo_expired;
  logic             rst_level, rst_assert;
  logic [DLY_W-1:0] dly_len;
  cpu_state_e       state;

  busown_seq seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_ready     (cmd_ready),
    .busack_n      (busack_n),
    .cpu_rst_sense (cpu_rst_sense),
    .dly_done      (dly_done),
    .tmo_expired   (tmo_expired),
    .dly_start     (dly_start),
    .dly_long      (dly_long),
    .tmo_start     (tmo_start),
    .rst_level     (rst_level),
    .rst_assert    (rst_assert),
    .rst_oe        (cpu_rst_oe),
    .busreq_n      (busreq_n),
    .bus_oe        (bus_oe),
    .state         (state)
  );

  assign dly_len = dly_long ? RUN_LEN : PULSE_LEN;

  busown_delay #(.W(DLY_W)) dly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dly_start),
    .len   (dly_len),
    .done  (dly_done)
  );

  busown_tick_timer #(
    .TICK_CYC      (TICK_CYC),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) tmo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmo_start),
    .expired (tmo_expired)
  );

  assign cpu_rst_drive = rst_assert ? rst_level : ~rst_level;
  assign cpu_state     = state;
  assign bus_acquired  = holds_bus(state);
endmodule

// File: rtl/busown_chk.sv
module busown_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       busack_n,
  input logic       cpu_rst_sense,
  input logic       cpu_rst_drive,
  input logic       cpu_rst_oe,
  input logic       busreq_n,
  input logic       bus_oe,
  input logic       bus_acquired,
  input logic [1:0] cpu_state,
  input logic       rst_level
);
  logic no_effect;
  assign no_effect = ((cmd_op == 2'd1) && cpu_state[0]) ||
                     ((cmd_op == 2'd2) && !cpu_state[0]) ||
                     ((cmd_op == 2'd3) && cpu_state[1]);

  a_r1_oe_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cpu_rst_oe));

  a_r1_learned_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_oe) |-> (cpu_rst_drive == $past(cpu_rst_sense)));

  a_r2_acq_has_drivers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_acquired && cmd_ready) |-> bus_oe);

  a_r3_grant_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_acquired) |-> !$past(busack_n));

  a_r8_run_released: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_state[1] && cmd_ready) |-> (cpu_rst_drive != rst_level));

  a_r10_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cpu_state) && cpu_state == 2'd0) |->
      (busreq_n && !bus_oe && cpu_rst_drive == rst_level));

  a_r11_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && no_effect) |=>
      ($stable(cpu_state) && $stable(busreq_n) && $stable(bus_oe) &&
       $stable(cpu_rst_drive) && cmd_ready));

  a_r13_oe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busreq_n);
endmodule

bind busown_ctrl busown_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_ready     (cmd_ready),
  .busack_n      (busack_n),
  .cpu_rst_sense (cpu_rst_sense),
  .cpu_rst_drive (cpu_rst_drive),
  .cpu_rst_oe    (cpu_rst_oe),
  .busreq_n      (busreq_n),
  .bus_oe        (bus_oe),
  .bus_acquired  (bus_acquired),
  .cpu_state     (cpu_state),
  .rst_level     (rst_level)
);

// File: tb/busown_ctrl_tb_top.sv
module busown_ctrl_tb_top;
  localparam int TICK  = 4;
  localparam int TOUT  = 5;
  localparam int PULSE = 3;
  localparam int RDLY  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, busack_n, cpu_rst_sense, cpu_rst_drive, cpu_rst_oe;
  logic busreq_n, bus_oe, bus_acquired;
  logic [1:0] cpu_state;
  logic resp_en = 1'b1;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  busown_ctrl #(.TICK_CYC(TICK), .TIMEOUT_TICKS(TOUT), .PULSE_CYC(PULSE),
                .RUN_DLY_CYC(RDLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .busack_n(busack_n), .cpu_rst_sense(cpu_rst_sense),
    .cpu_rst_drive(cpu_rst_drive), .cpu_rst_oe(cpu_rst_oe), .busreq_n(busreq_n),
    .bus_oe(bus_oe), .bus_acquired(bus_acquired), .cpu_state(cpu_state));

  // CPU model: acknowledge follows request one cycle later when enabled.
  initial begin
    busack_n = 1'b1;
    forever begin
      @(negedge clk);
      busack_n = resp_en ? busreq_n : 1'b1;
    end
  end

  // vector: {cmd[7:6], resp[5], state[4:3], busreq_n[2], rst_asserted[1], bus_oe[0]}
  localparam logic [7:0] VEC [0:14] = '{
    {2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    {2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    {2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1},
    {2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1},
    {2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
    {2'd3, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    {2'd2, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 13:        return "R3";
      1, 4, 5, 12:  return "R11";
      2:            return "R9";
      3:            return "R7";
      6, 9:         return "R5";
      7, 10:        return "R10";
      8:            return "R8";
      11:           return "R4";
      default:      return "R6";
    endcase
  endfunction

  function automatic logic rst_on();
    return cpu_rst_oe && (cpu_rst_drive == cpu_rst_sense);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 300 && !cmd_ready; k++) @(negedge clk);
  endtask

  // Returns at the first falling edge after the command was accepted.
  task automatic issue(logic [1:0] op);
    wait_ready();
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(logic level);
    @(negedge clk);
    rst_n = 1'b0;
    cpu_rst_sense = level;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic req_seen_high;
    cpu_rst_sense = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", cpu_rst_oe, 0);
    chk("R1 busreq_n in reset", busreq_n, 1);
    chk("R1 bus_oe in reset", bus_oe, 0);
    chk("R1 ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after init", cpu_rst_oe, 1);
    chk("R1 drive low level", cpu_rst_drive, 0);
    chk("R1 state", cpu_state, 0);
    chk("R1 ready", cmd_ready, 1);

    for (int i = 0; i < 15; i++) begin
      resp_en = VEC[i][5];
      issue(VEC[i][7:6]);
      wait_ready();
      chk({vec_tag(i), " state"}, cpu_state, VEC[i][4:3]);
      chk({vec_tag(i), " busreq_n"}, busreq_n, VEC[i][2]);
      chk({vec_tag(i), " reset"}, rst_on(), VEC[i][1]);
      chk({vec_tag(i), " bus_oe"}, bus_oe, VEC[i][0]);
      chk("R2 acquired flag", bus_acquired, VEC[i][3]);
    end

    // R8: reset held RDLY cycles on Run from RESET
    resp_en = 1'b1;
    issue(2'd3);
    cnt = 0;
    while (rst_on() && cnt < 200) begin cnt++; @(negedge clk); end
    chk("R8 reset hold cycles", cnt, RDLY);
    wait_ready();
    chk("R8 state running", cpu_state, 2);

    // R9: pulse width on Run from RESET_ACQ, busreq_n held low
    issue(2'd0);
    issue(2'd1);
    wait_ready();
    issue(2'd3);
    cnt = 0;
    req_seen_high = 1'b0;
    while (!bus_oe && cnt < 200) begin
      if (rst_on()) cnt++;
      if (busreq_n) req_seen_high = 1'b1;
      @(negedge clk);
    end
    chk("R9 pulse cycles", cnt, PULSE);
    chk("R9 busreq_n held low", req_seen_high, 0);
    wait_ready();
    chk("R9 state", cpu_state, 3);

    // R6: Release from RESET_ACQ keeps busreq_n low PULSE cycles under reset
    issue(2'd0);
    issue(2'd1);
    wait_ready();
    issue(2'd2);
    chk("R6 reset asserted at once", rst_on(), 1);
    cnt = 0;
    while (!busreq_n && cnt < 200) begin cnt++; @(negedge clk); end
    chk("R6 busreq_n low cycles", cnt, PULSE);
    wait_ready();
    chk("R6 state", cpu_state, 0);

    // R4: timeout from RESET, exact length
    resp_en = 1'b0;
    issue(2'd1);
    chk("R3 reset released on request", rst_on(), 0);
    cnt = 0;
    while (!busreq_n && cnt < 500) begin cnt++; @(negedge clk); end
    chk("R4 timeout cycles", cnt, TOUT * TICK + 1);
    wait_ready();
    chk("R4 reset reasserted", rst_on(), 1);
    chk("R4 state", cpu_state, 0);

    // R12: command during busy Run delay is not taken
    resp_en = 1'b1;
    issue(2'd3);
    chk("R12 ready low while busy", cmd_ready, 0);
    cmd_valid = 1'b1;
    cmd_op    = 2'd0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready();
    @(negedge clk);
    chk("R12 busy command dropped", cpu_state, 2);
    chk("R12 reset stays released", rst_on(), 0);

    // R1: high active reset level learned
    do_reset(1'b1);
    chk("R1 drive high level", cpu_rst_drive, 1);
    chk("R1 oe high level", cpu_rst_oe, 1);
    issue(2'd3);
    wait_ready();
    chk("R1 released is low", cpu_rst_drive, 0);
    chk("R8 state after run", cpu_state, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule